// File: doc/BRIEF.md
# ECC-Protected Register File

This block is a register file with two read ports and one write port, for a processor core that needs protection against upsets in its register storage. Each write is stored as a SECDED code word: a Hamming code with an extra parity bit over the whole word. Each read decodes the stored word. A single flipped bit is corrected before the data leaves the block. Two flipped bits are reported as unrecoverable.

Decode outcomes are reported one cycle after the read on a small event vector that outside monitors can observe. An unrecoverable error also raises an exception request. A separate handler-mode input marks errors that arrive while the core is already handling an exception, and those errors get their own event bit. For test, an injection control arms an XOR mask against one register index. The next write to that register stores a corrupted code word, so error paths can be exercised without faulty hardware.

Top module: `ecc_regfile`

## Requirements
- R1: A written value reads back unchanged, with no event and no exception. Storage resets to the code word of zero. In the code word, bit 0 is overall parity, the bits at positions 1, 2, 4, 8, 16 and 32 are Hamming check bits, and the data bits fill the remaining positions from low to high.
- R2: When a read entry has a single flipped bit, in any of its 39 positions including the parity bit, the read returns the corrected data. Event bit 1 is set in the next cycle and no exception request is raised.
- R3: When a read entry has two flipped bits, event bit 2 is set and excReq is 1 in the cycle after the read.
- R4: Event bit 0 is set in the cycle after a read with an unrecoverable error only when inHandler was 1 during that read. It is never set for corrected errors.
- R5: Register 0 always reads as zero and never reports an error. Writes to it and injection into it have no effect.
- R6: An injection stores the mask and arms it for the named register. The mask is XORed into the code word of the next write to that register only. Writes to other registers are unaffected, and the following write to the target is clean.
- R7: When a read and a write address the same register in the same cycle, the read returns the contents from before the write.
- R8: Events and excReq last one cycle. eventValid is 1 exactly when some event bit is 1. Reads with their enable low report nothing.
- R9: Both read ports decode independently, and their outcomes in the same cycle merge into one event vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | 5 | Write register index |
| wrData | input | 32 | Write data |
| rdEnA | input | 1 | Port A read enable (qualifies error reporting) |
| rdAddrA | input | 5 | Port A register index |
| rdDataA | output | 32 | Port A corrected data, same cycle |
| rdEnB | input | 1 | Port B read enable |
| rdAddrB | input | 5 | Port B register index |
| rdDataB | output | 32 | Port B corrected data, same cycle |
| injEn | input | 1 | Arm an error injection |
| injAddr | input | 5 | Register targeted by injection |
| injMask | input | 39 | XOR mask applied to the stored code word |
| inHandler | input | 1 | Core is already in exception-handler mode |
| eventBus | output | 3 | Bit 0 nested unrecoverable, bit 1 corrected, bit 2 unrecoverable |
| eventValid | output | 1 | Event vector carries a report this cycle |
| excReq | output | 1 | Exception request for an unrecoverable error |

## Verification
A read can land in the same cycle as a write to the same register, including the write that carries an armed injection. The bench drives both in one cycle. It requires the read to return the old clean value and report no event in the next cycle, and it requires the corruption to show only on a later read. The bench also corrects a single-bit error on port A while port B sees a double-bit error in the same cycle, and checks that one event vector carries both outcomes together with the exception request.

// File: rtl/eccrf_pkg.sv
package eccrf_pkg;

  localparam int RD_PORTS   = 2;
  localparam int EVT_W      = 3;
  localparam int EVT_NESTED = 0;
  localparam int EVT_CORR   = 1;
  localparam int EVT_UNCORR = 2;

  // strobes from control to datapath
  typedef struct packed {
    logic wrEn;
    logic injLoad;
    logic injApply;
  } rfStrobe_t;

  // per-port decode outcome, the two flags are exclusive
  typedef struct packed {
    logic corr;
    logic uncorr;
  } rfDecStat_t;

  // Hamming check bits needed for a data width (overall parity not counted)
  function automatic int checkBits(input int dataW);
    int p;
    p = 0;
    while ((1 << p) < dataW + p + 1) p++;
    return p;
  endfunction

endpackage

// File: rtl/eccrf_datapath.sv
module eccrf_datapath
  import eccrf_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 32,
  parameter int ADDR_W   = 5,
  parameter int CHK_W    = 6,
  parameter int CODE_W   = 39
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rfStrobe_t         strb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [CODE_W-1:0] injMask,
  input  logic [ADDR_W-1:0] rdAddr [RD_PORTS],
  output logic [DATA_W-1:0] rdData [RD_PORTS],
  output rfDecStat_t        stat   [RD_PORTS]
);

  // positions covered by Hamming check bit b
  function automatic logic [CODE_W-1:0] coverMask(input int b);
    logic [CODE_W-1:0] m;
    m = '0;
    for (int pos = 1; pos < CODE_W; pos++)
      if (((pos >> b) & 1) == 1) m |= CODE_W'(1) << pos;
    return m;
  endfunction

  function automatic bit isDataPos(input int pos);
    return (pos & (pos - 1)) != 0;
  endfunction

  function automatic logic [CODE_W-1:0] encodeWord(input logic [DATA_W-1:0] d);
    logic [CODE_W-1:0] c;
    logic [DATA_W-1:0] rest;
    c    = '0;
    rest = d;
    for (int pos = 1; pos < CODE_W; pos++) begin
      if (isDataPos(pos)) begin
        if (rest[0]) c |= CODE_W'(1) << pos;
        rest = rest >> 1;
      end
    end
    for (int b = 0; b < CHK_W; b++)
      if (^(c & coverMask(b))) c |= CODE_W'(1) << (1 << b);
    if (^c) c |= CODE_W'(1);
    return c;
  endfunction

  function automatic logic [CHK_W-1:0] syndromeOf(input logic [CODE_W-1:0] c);
    logic [CHK_W-1:0] s;
    s = '0;
    for (int b = 0; b < CHK_W; b++)
      if (^(c & coverMask(b))) s |= CHK_W'(1) << b;
    return s;
  endfunction

  function automatic logic [DATA_W-1:0] extractData(input logic [CODE_W-1:0] c);
    logic [DATA_W-1:0] d;
    logic [CODE_W-1:0] sh;
    int k;
    d  = '0;
    sh = c;
    k  = 0;
    for (int pos = 0; pos < CODE_W; pos++) begin
      if (isDataPos(pos)) begin
        d |= DATA_W'(sh[0]) << k;
        k++;
      end
      sh = sh >> 1;
    end
    return d;
  endfunction

  // injection mask holding register
  logic [CODE_W-1:0] injMaskQ;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            injMaskQ <= '0;
    else if (strb.injLoad) injMaskQ <= injMask;
  end

  logic [CODE_W-1:0] wrCode;
  assign wrCode = encodeWord(wrData) ^ (strb.injApply ? injMaskQ : '0);

  // storage, entry 0 is a constant zero code word
  logic [CODE_W-1:0] store [NUM_REGS];

  for (genvar r = 0; r < NUM_REGS; r++) begin : gEntry
    if (r == 0) begin : gZero
      assign store[r] = '0;
    end else begin : gReg
      logic [CODE_W-1:0] word;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                    word <= '0;
        else if (strb.wrEn && wrAddr == ADDR_W'(r))    word <= wrCode;
      end
      assign store[r] = word;
    end
  end

  // read decode, one per port
  for (genvar p = 0; p < RD_PORTS; p++) begin : gRead
    logic [CODE_W-1:0] rawWord;
    logic [CODE_W-1:0] fixWord;
    logic [CHK_W-1:0]  syn;
    logic              parOdd;
    rfDecStat_t        st;

    always_comb begin
      rawWord = store[rdAddr[p]];
      syn     = syndromeOf(rawWord);
      parOdd  = ^rawWord;
      fixWord = rawWord;
      st      = '0;
      if (parOdd) begin
        if (int'(syn) < CODE_W) begin
          st.corr = 1'b1;
          fixWord = rawWord ^ (CODE_W'(1) << syn);
        end else begin
          st.uncorr = 1'b1;
        end
      end else if (syn != '0) begin
        st.uncorr = 1'b1;
      end
    end

    assign rdData[p] = extractData(fixWord);
    assign stat[p]   = st;

    assert_zero_reg_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rdAddr[p] == '0) |-> (rdData[p] == '0 && !stat[p].corr && !stat[p].uncorr))
      else $error("register 0 read not clean");

    assert_excl_outcome_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(stat[p].corr && stat[p].uncorr))
      else $error("decode outcome not exclusive");
  end

endmodule

// File: rtl/eccrf_ctrl.sv
module eccrf_ctrl
  import eccrf_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic                injEn,
  input  logic [ADDR_W-1:0]   injAddr,
  input  logic [RD_PORTS-1:0] rdEn,
  input  rfDecStat_t          stat [RD_PORTS],
  input  logic                inHandler,
  output rfStrobe_t           strb,
  output logic [EVT_W-1:0]    eventBus,
  output logic                eventValid,
  output logic                excReq
);

  logic              injArmed;
  logic [ADDR_W-1:0] injAddrQ;

  always_comb begin
    strb          = '0;
    strb.wrEn     = wrEn && (wrAddr != '0);
    strb.injLoad  = injEn;
    strb.injApply = strb.wrEn && injArmed && (wrAddr == injAddrQ);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      injArmed <= 1'b0;
      injAddrQ <= '0;
    end else if (injEn) begin
      injArmed <= (injAddr != '0);
      injAddrQ <= injAddr;
    end else if (strb.injApply) begin
      injArmed <= 1'b0;
    end
  end

  logic anyCorr;
  logic anyUncorr;
  always_comb begin
    anyCorr   = 1'b0;
    anyUncorr = 1'b0;
    for (int p = 0; p < RD_PORTS; p++) begin
      if (rdEn[p]) begin
        anyCorr   = anyCorr   | stat[p].corr;
        anyUncorr = anyUncorr | stat[p].uncorr;
      end
    end
  end

  logic [EVT_W-1:0] evtNext;
  always_comb begin
    evtNext             = '0;
    evtNext[EVT_CORR]   = anyCorr;
    evtNext[EVT_UNCORR] = anyUncorr;
    evtNext[EVT_NESTED] = anyUncorr && inHandler;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eventBus <= '0;
      excReq   <= 1'b0;
    end else begin
      eventBus <= evtNext;
      excReq   <= anyUncorr;
    end
  end

  assign eventValid = |eventBus;

  assert_corr_event_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rdEn[0] && stat[0].corr) |=> eventBus[EVT_CORR])
    else $error("corrected read not reported");

  assert_corr_no_exc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rdEn[0] && stat[0].corr && !(rdEn[1] && stat[1].uncorr)) |=> !excReq)
    else $error("exception on corrected read");

  assert_uncorr_exc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rdEn[1] && stat[1].uncorr) |=> (excReq && eventBus[EVT_UNCORR]))
    else $error("unrecoverable read not raised");

  assert_nested_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    eventBus[EVT_NESTED] |-> (excReq && $past(inHandler)))
    else $error("nested flag without handler mode");

  assert_quiet_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rdEn == '0) |=> (eventBus == '0 && !excReq))
    else $error("event without enabled read");

  assert_inject_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.injApply && !injEn) |=> !injArmed)
    else $error("injection stayed armed after use");

endmodule

// File: rtl/ecc_regfile.sv
module ecc_regfile
  import eccrf_pkg::*;
#(
  parameter  int DATA_W   = 32,
  parameter  int NUM_REGS = 32,
  localparam int ADDR_W   = $clog2(NUM_REGS),
  localparam int CHK_W    = checkBits(DATA_W),
  localparam int CODE_W   = DATA_W + CHK_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEnA,
  input  logic [ADDR_W-1:0] rdAddrA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic              rdEnB,
  input  logic [ADDR_W-1:0] rdAddrB,
  output logic [DATA_W-1:0] rdDataB,
  input  logic              injEn,
  input  logic [ADDR_W-1:0] injAddr,
  input  logic [CODE_W-1:0] injMask,
  input  logic              inHandler,
  output logic [EVT_W-1:0]  eventBus,
  output logic              eventValid,
  output logic              excReq
);

  rfStrobe_t         strb;
  rfDecStat_t        stat   [RD_PORTS];
  logic [ADDR_W-1:0] rdAddr [RD_PORTS];
  logic [DATA_W-1:0] rdData [RD_PORTS];

  assign rdAddr[0] = rdAddrA;
  assign rdAddr[1] = rdAddrB;
  assign rdDataA   = rdData[0];
  assign rdDataB   = rdData[1];

  eccrf_ctrl #(
    .ADDR_W(ADDR_W)
  ) uCtrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wrEn       (wrEn),
    .wrAddr     (wrAddr),
    .injEn      (injEn),
    .injAddr    (injAddr),
    .rdEn       ({rdEnB, rdEnA}),
    .stat       (stat),
    .inHandler  (inHandler),
    .strb       (strb),
    .eventBus   (eventBus),
    .eventValid (eventValid),
    .excReq     (excReq)
  );

  eccrf_datapath #(
    .DATA_W   (DATA_W),
    .NUM_REGS (NUM_REGS),
    .ADDR_W   (ADDR_W),
    .CHK_W    (CHK_W),
    .CODE_W   (CODE_W)
  ) uData (
    .clk     (clk),
    .rst_n   (rst_n),
    .strb    (strb),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .injMask (injMask),
    .rdAddr  (rdAddr),
    .rdData  (rdData),
    .stat    (stat)
  );

endmodule

// File: tb/ecc_regfile_test.sv
module ecc_regfile_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wrEn = 1'b0;
  logic [4:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic        rdEnA = 1'b0;
  logic [4:0]  rdAddrA = '0;
  logic [31:0] rdDataA;
  logic        rdEnB = 1'b0;
  logic [4:0]  rdAddrB = '0;
  logic [31:0] rdDataB;
  logic        injEn = 1'b0;
  logic [4:0]  injAddr = '0;
  logic [38:0] injMask = '0;
  logic        inHandler = 1'b0;
  logic [2:0]  eventBus;
  logic        eventValid;
  logic        excReq;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  ecc_regfile uut (
    .clk(clk), .rst_n(rst_n),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEnA(rdEnA), .rdAddrA(rdAddrA), .rdDataA(rdDataA),
    .rdEnB(rdEnB), .rdAddrB(rdAddrB), .rdDataB(rdDataB),
    .injEn(injEn), .injAddr(injAddr), .injMask(injMask),
    .inHandler(inHandler),
    .eventBus(eventBus), .eventValid(eventValid), .excReq(excReq)
  );

  // {addr[5], data[32], mask[39], handler[1], expected events[3]}
  localparam int NVEC = 8;
  localparam logic [79:0] VEC [NVEC] = '{
    {5'd3,  32'hDEADBEEF, 39'h0,           1'b0, 3'b000},
    {5'd4,  32'h12345678, 39'h20,          1'b0, 3'b010},
    {5'd9,  32'hFFFFFFFF, 39'h1,           1'b0, 3'b010},
    {5'd10, 32'h00000000, 39'h40_0000_0000, 1'b1, 3'b010},
    {5'd11, 32'hA5A5A5A5, 39'h20008,       1'b0, 3'b100},
    {5'd12, 32'h0F0F0F0F, 39'h6,           1'b1, 3'b101},
    {5'd31, 32'h80000001, 39'h1_0000_0000, 1'b0, 3'b010},
    {5'd1,  32'h55AA55AA, 39'h0,           1'b1, 3'b000}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doInject(input logic [4:0] a, input logic [38:0] m);
    @(negedge clk);
    injEn = 1'b1; injAddr = a; injMask = m;
    @(negedge clk);
    injEn = 1'b0; injMask = '0;
  endtask

  task automatic doWrite(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doReadA(input logic [4:0] a, input logic hand,
                         output logic [31:0] d, output logic [2:0] ev,
                         output logic ex, output logic vld);
    @(negedge clk);
    rdEnA = 1'b1; rdAddrA = a; inHandler = hand;
    #1 d = rdDataA;
    @(negedge clk);
    rdEnA = 1'b0; inHandler = 1'b0;
    ev = eventBus; ex = excReq; vld = eventValid;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #(4 * 100000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog actual=hung expected=done");
    finish();
  end

  initial begin
    logic [31:0] d;
    logic [2:0]  ev;
    logic        ex;
    logic        vld;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    chk("R1 reset events", {61'd0, eventBus}, 64'd0);
    chk("R1 reset excReq", {63'd0, excReq}, 64'd0);
    doReadA(5'd3, 1'b0, d, ev, ex, vld);
    chk("R1 reset contents", {32'd0, d}, 64'd0);
    chk("R1 reset read events", {61'd0, ev}, 64'd0);

    // table walk: inject (optional), write, read on port A
    for (int i = 0; i < NVEC; i++) begin
      logic [4:0]  va;
      logic [31:0] vd;
      logic [38:0] vm;
      logic        vh;
      logic [2:0]  ve;
      {va, vd, vm, vh, ve} = VEC[i];
      if (vm != '0) doInject(va, vm);
      doWrite(va, vd);
      doReadA(va, vh, d, ev, ex, vld);
      if (!ve[2]) chk("R2 corrected data", {32'd0, d}, {32'd0, vd});
      chk("R3 R4 event vector", {61'd0, ev}, {61'd0, ve});
      chk("R3 exception request", {63'd0, ex}, {63'd0, ve[2]});
      chk("R8 valid matches events", {63'd0, vld}, {63'd0, (ve != 3'b000)});
    end

    // R8: events are single-cycle pulses
    doReadA(5'd11, 1'b0, d, ev, ex, vld);
    chk("R3 repeat unrecoverable", {61'd0, ev}, 64'h4);
    @(negedge clk);
    chk("R8 pulse drops", {60'd0, eventBus, excReq}, 64'd0);

    // R8: disabled reads of a corrupted entry report nothing
    @(negedge clk);
    rdAddrA = 5'd11; rdAddrB = 5'd4; rdEnA = 1'b0; rdEnB = 1'b0; inHandler = 1'b1;
    @(negedge clk);
    inHandler = 1'b0;
    chk("R8 disabled read silent", {60'd0, eventBus, excReq}, 64'd0);

    // R9: port A corrects while port B is unrecoverable, same cycle
    @(negedge clk);
    rdEnA = 1'b1; rdAddrA = 5'd4; rdEnB = 1'b1; rdAddrB = 5'd11;
    #1 chk("R9 port A corrected", {32'd0, rdDataA}, 64'h12345678);
    @(negedge clk);
    rdEnA = 1'b0; rdEnB = 1'b0;
    chk("R9 merged events", {61'd0, eventBus}, 64'h6);
    chk("R9 exception", {63'd0, excReq}, 64'd1);

    // R9: port B alone corrects
    @(negedge clk);
    rdEnB = 1'b1; rdAddrB = 5'd9;
    #1 chk("R9 port B corrected", {32'd0, rdDataB}, 64'hFFFFFFFF);
    @(negedge clk);
    rdEnB = 1'b0;
    chk("R9 port B event", {61'd0, eventBus}, 64'h2);

    // R5: register 0
    doWrite(5'd0, 32'hFFFF0000);
    doReadA(5'd0, 1'b0, d, ev, ex, vld);
    chk("R5 r0 reads zero", {32'd0, d}, 64'd0);
    chk("R5 r0 no event", {61'd0, ev}, 64'd0);
    doInject(5'd0, 39'h6);
    doWrite(5'd0, 32'h1);
    doReadA(5'd0, 1'b1, d, ev, ex, vld);
    chk("R5 r0 after injection", {32'd0, d}, 64'd0);
    chk("R5 r0 injection no event", {60'd0, ev, ex}, 64'd0);

    // R7: read and write same register in one cycle
    doWrite(5'd5, 32'h11111111);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 5'd5; wrData = 32'h22222222;
    rdEnA = 1'b1; rdAddrA = 5'd5;
    #1 chk("R7 read returns old", {32'd0, rdDataA}, 64'h11111111);
    @(negedge clk);
    wrEn = 1'b0; rdEnA = 1'b0;
    doReadA(5'd5, 1'b0, d, ev, ex, vld);
    chk("R7 new value later", {32'd0, d}, 64'h22222222);

    // R7 + R6: read colliding with the injected write
    doWrite(5'd13, 32'hCAFEF00D);
    doInject(5'd13, 39'h6);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 5'd13; wrData = 32'h0BADCAFE;
    rdEnA = 1'b1; rdAddrA = 5'd13;
    #1 chk("R7 old clean value", {32'd0, rdDataA}, 64'hCAFEF00D);
    @(negedge clk);
    wrEn = 1'b0; rdEnA = 1'b0;
    chk("R7 collision no event", {60'd0, eventBus, excReq}, 64'd0);
    doReadA(5'd13, 1'b0, d, ev, ex, vld);
    chk("R6 injected double seen", {61'd0, ev}, 64'h4);

    // R6: next write to target is clean again
    doWrite(5'd13, 32'h13131313);
    doReadA(5'd13, 1'b0, d, ev, ex, vld);
    chk("R6 rewrite clean data", {32'd0, d}, 64'h13131313);
    chk("R6 rewrite clean events", {61'd0, ev}, 64'd0);

    // R6: other registers unaffected while armed
    doInject(5'd14, 39'h400);
    doWrite(5'd15, 32'h15151515);
    doReadA(5'd15, 1'b0, d, ev, ex, vld);
    chk("R6 non-target clean", {61'd0, ev}, 64'd0);
    doWrite(5'd14, 32'h14141414);
    doReadA(5'd14, 1'b0, d, ev, ex, vld);
    chk("R6 target corrected data", {32'd0, d}, 64'h14141414);
    chk("R6 target single event", {61'd0, ev}, 64'h2);

    // R4: unrecoverable outside handler has no nested flag
    doReadA(5'd12, 1'b0, d, ev, ex, vld);
    chk("R4 no nested outside handler", {61'd0, ev}, 64'h4);

    finish();
  end

endmodule